// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider (Restoring / Non-Restoring)

This block divides two unsigned W-bit integers and returns a W-bit quotient and a W-bit remainder. It produces one quotient bit per clock cycle from a shared datapath. That datapath holds a W+1-bit signed partial remainder (the accumulator), a shift register that starts with the dividend and ends with the quotient, and a register for the divisor. A mode input picks the iteration rule for each division. The restoring rule adds the divisor back whenever a trial subtraction goes negative. The non-restoring rule keeps the negative partial remainder and adds the divisor on the next step instead. When the non-restoring rule ends with a negative partial remainder, one extra correction cycle adds the divisor once more. Both rules give identical results.

The caller sets the operands and the mode and pulses start. It then waits for the one-cycle done pulse. The results stay on the outputs until the next accepted start. A zero divisor does not iterate. It raises a divide-by-zero flag and returns fixed results.

Top module: `seq_divider`

## Requirements
- R1: After reset, done_o, div_zero_o, quotient_o and remainder_o are all 0.
- R2: With mode_i = 0 (restoring) and a nonzero divisor, quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor when done_o is high.
- R3: With mode_i = 1 (non-restoring) and a nonzero divisor, the results are the same as in R2.
- R4: In restoring mode, done_o goes high exactly W clock edges after the edge that samples start_i.
- R5: In non-restoring mode, done_o goes high W edges after the start edge when quotient bit 0 is 1. When quotient bit 0 is 0 it goes high W+1 edges after the start edge, because of the one remainder-correction cycle.
- R6: A zero divisor sets div_zero_o, sets quotient_o to all ones and remainder_o to the dividend, and raises done_o on the same edge that samples start_i.
- R7: A division with a nonzero divisor clears div_zero_o.
- R8: done_o is high for exactly one cycle per division.
- R9: A start_i pulse that arrives while a division is in progress is ignored. The running division's results and latency are unchanged, even when the new operands carry a zero divisor.
- R10: After done_o, quotient_o, remainder_o and div_zero_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division with the current operands and mode |
| mode_i | input | 1 | 0 = restoring rule, 1 = non-restoring rule |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quotient_o | output | W | Quotient, valid from done_o |
| remainder_o | output | W | Remainder, valid from done_o |
| div_zero_o | output | 1 | Divisor was zero, valid from done_o |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the non-restoring correction cycle. It happens only when the last partial remainder is negative, and that is exactly the case where the quotient comes out even. The bench runs every dividend/divisor pair of a 4-bit instance in both modes. This covers every case that needs the correction and every case that does not. The bench predicts the extra cycle from the expected quotient's low bit. A start pulse with a zero divisor is injected in the middle of some divisions, to show that a busy divider ignores it.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;

  typedef enum logic {
    MODE_RESTORE    = 1'b0,
    MODE_NONRESTORE = 1'b1
  } sdiv_mode_e;
endpackage

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int W = 8
) (
  input  logic [W:0]   acc_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  input  logic         nonrest_i,
  output logic [W:0]   acc_o,
  output logic [W-1:0] quo_o,
  output logic         neg_o
);
  localparam int EW = W + 2;

  logic [EW-1:0] sh, dvs_x, sum, dif, pick;
  logic          q_bit;
  logic [W:0]    quo_ext;

  always_comb begin
    // 2*acc + next dividend bit, exact in EW signed bits
    sh    = {acc_i, quo_i[W-1]};
    dvs_x = {2'b00, dvs_i};
    sum   = sh + dvs_x;
    dif   = sh - dvs_x;
    if (nonrest_i) begin
      pick  = acc_i[W] ? sum : dif;
      acc_o = pick[W:0];
      q_bit = ~pick[EW-1];
    end else begin
      pick  = dif;
      q_bit = ~dif[EW-1];
      acc_o = dif[EW-1] ? sh[W:0] : dif[W:0];
    end
    neg_o   = acc_o[W];
    quo_ext = {quo_i, q_bit};
    quo_o   = quo_ext[W-1:0];
  end
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dvs_zero_i,
  input  logic nonrest_i,
  input  logic last_neg_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(1);

  sdiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (dvs_zero_i) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_INIT;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_LAST) begin
            if (nonrest_i && last_neg_i) begin
              state_q <= ST_FIX;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q != '0));
  // R5
  fix_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |-> nonrest_i);
  // R5
  fix_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIX) |=> (state_q == ST_IDLE) && done_q);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import sdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         div_zero_o,
  output logic         done_o
);
  logic [W:0]   acc_q, acc_nx;
  logic [W-1:0] quo_q, quo_nx, dvs_q;
  logic         nonrest_q, dz_q;
  logic         load, step, fix, busy, last_neg;
  logic         dvs_zero;

  assign dvs_zero = (divisor_i == '0);

  sdiv_step #(.W(W)) u_step (
    .acc_i     (acc_q),
    .quo_i     (quo_q),
    .dvs_i     (dvs_q),
    .nonrest_i (nonrest_q),
    .acc_o     (acc_nx),
    .quo_o     (quo_nx),
    .neg_o     (last_neg)
  );

  sdiv_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dvs_zero_i (dvs_zero),
    .nonrest_i  (nonrest_q),
    .last_neg_i (last_neg),
    .load_o     (load),
    .step_o     (step),
    .fix_o      (fix),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      nonrest_q <= MODE_RESTORE;
      dz_q      <= 1'b0;
    end else if (load) begin
      nonrest_q <= mode_i;
      dvs_q     <= divisor_i;
      dz_q      <= dvs_zero;
      if (dvs_zero) begin
        acc_q <= {1'b0, dividend_i};
        quo_q <= '1;
      end else begin
        acc_q <= '0;
        quo_q <= dividend_i;
      end
    end else if (step) begin
      acc_q <= acc_nx;
      quo_q <= quo_nx;
    end else if (fix) begin
      acc_q <= acc_q + {1'b0, dvs_q};
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = acc_q[W-1:0];
  assign div_zero_o  = dz_q;

  // R2
  rest_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (nonrest_q == MODE_RESTORE)) |-> !acc_q[W]);
  // R3
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (!acc_q[W] && (remainder_o < dvs_q)));
  // R6
  dz_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> (quotient_o == '1));
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(dvs_q) && $stable(nonrest_q)));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i && !done_o) |=>
      ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] quotient_o, remainder_o;
  logic         div_zero_o, done_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  seq_divider #(.W(W)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .div_zero_o  (div_zero_o),
    .done_o      (done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 200000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_div(input int x, input int y, input int md, input bit inj);
    int eq, er, elat, lat;
    int q0, r0, z0;
    string tq;
    @(negedge clk);
    dividend_i = W'(x);
    divisor_i  = W'(y);
    mode_i     = md[0];
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < W + 4) begin
      if (inj && lat == 1) begin
        start_i    = 1'b1;   // R9: must be ignored
        dividend_i = W'(~x);
        divisor_i  = '0;
        mode_i     = ~md[0];
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    if (y == 0) begin
      eq = N - 1; er = x; elat = 0;
    end else begin
      eq = x / y; er = x % y;
      elat = (md == 1 && (eq % 2) == 0) ? W + 1 : W;
    end
    tq = (y == 0) ? "R6" : (inj ? "R9" : (md == 1 ? "R3" : "R2"));
    chk(done_o == 1'b1, tq, int'(done_o), 1);
    chk(int'(quotient_o) == eq, tq, int'(quotient_o), eq);
    chk(int'(remainder_o) == er, tq, int'(remainder_o), er);
    chk(int'(div_zero_o) == (y == 0 ? 1 : 0), (y == 0) ? "R6" : "R7",
        int'(div_zero_o), (y == 0 ? 1 : 0));
    chk(lat == elat, (y == 0) ? "R6" : (md == 1 ? "R5" : "R4"), lat, elat);
    q0 = int'(quotient_o); r0 = int'(remainder_o); z0 = int'(div_zero_o);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", int'(done_o), 0);
    @(negedge clk);
    @(negedge clk);
    chk(int'(quotient_o) == q0 && int'(remainder_o) == r0 && int'(div_zero_o) == z0,
        "R10", int'(quotient_o), q0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    chk(div_zero_o == 1'b0, "R1", int'(div_zero_o), 0);
    chk(quotient_o == '0, "R1", int'(quotient_o), 0);
    chk(remainder_o == '0, "R1", int'(remainder_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int md = 0; md < 2; md++) begin
      for (int x = 0; x < N; x++) begin
        for (int y = 0; y < N; y++) begin
          run_div(x, y, md, ((x + 3 * y + md) % 5) == 0);
        end
      end
    end
    // R7: flag clears after a zero-divisor run
    run_div(9, 0, 0, 1'b0);
    run_div(9, 2, 1, 1'b0);
    chk(div_zero_o == 1'b0, "R7", int'(div_zero_o), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule